// File: doc/BRIEF.md
# Von Neumann Byte Sampler

This block takes a single raw random bit per clock and assembles bias-free bytes from it. Each clock it shifts the raw bit into a two-bit pair register. On every second clock it examines the pair held there. The pairs it examines never share a bit. A pair whose two bits differ yields one output bit. A pair whose two bits match is discarded. Eight accepted bits form a byte, which appears on the data output together with a one-cycle valid pulse.

The block sits behind an entropy source. The global enable acts as its reset: while it is low, every register is cleared. The sampler enable is a separate input. It is raised once the entropy source reports that it is fully running. Whenever the sampler enable is low, the pair phase, the bit count and the partial byte restart. The last finished byte stays on the data output until the next one replaces it.

Top module: `vn_byte_sampler`

## Requirements
- R1: While `enable` is low at a clock edge, that edge clears every register. After it, `byte_valid` is 0, `byte_out` is 0 and any partly collected byte is discarded.
- R2: While `sample_en` is low, the pair phase, the accepted-bit count and the partial byte restart. `byte_out` keeps the last finished byte.
- R3: Let edge k be the first rising edge with `sample_en` high. Pairs are formed from the raw bits sampled at edges k and k+1, then at k+2 and k+3, and so on. Each pair is judged at the edge two cycles after its first bit was sampled.
- R4: A pair sampled as 0 then 1 contributes a 0. A pair sampled as 1 then 0 contributes a 1. Each new bit enters at the LSB, so the first accepted bit of a byte ends up in `byte_out[7]`.
- R5: Pairs 00 and 11 contribute no bit and do not advance the accepted-bit count.
- R6: On the edge that accepts the eighth bit, `byte_out` takes the finished byte. `byte_valid` is high for exactly the one cycle after that edge. `byte_out` holds its value until the next byte completes.
- R7: If every pair is accepted, the first byte is flagged after edge k+16. Each further byte follows 16 cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also samples the raw bit |
| enable | input | 1 | High-active run; low clears all state |
| sample_en | input | 1 | Starts pairing; low restarts pair phase and partial byte |
| raw_bit | input | 1 | Raw random bit from the entropy source |
| byte_out | output | 8 | Last completed byte |
| byte_valid | output | 1 | One-cycle pulse when `byte_out` is new |

## Verification
Suppose the pair phase is off by one cycle. Bits from neighbouring pairs are then combined. A repeated 1001 stream would then produce no bytes at all, which shows within 16 cycles. A count that advances on matching pairs makes bytes complete early when junk pairs are mixed in, so the first valid pulse arrives at the wrong edge. A partial byte that is not cleared by either enable shortens the next byte's latency below 16 cycles. A swapped bit mapping or a wrong shift direction is visible in the first byte's value.

// File: rtl/vn_byte_sampler.sv
module vn_byte_sampler #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              enable,
  input  logic              sample_en,
  input  logic              raw_bit,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_valid
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [1:0]        pair_q;
  logic              odd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic [BYTE_W-1:0] byte_q;
  logic              valid_q;

  wire judge   = sample_en & ~odd_q;
  wire take    = judge & (pair_q[1] ^ pair_q[0]);
  wire new_bit = pair_q[1];
  wire last    = take & (cnt_q == CNT_LAST);
  wire [BYTE_W-1:0] next_shift = {shift_q[BYTE_W-2:0], new_bit};

  always_ff @(posedge clk) begin
    if (!enable) begin
      pair_q  <= '0;
      odd_q   <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else if (!sample_en) begin
      pair_q  <= '0;
      odd_q   <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      valid_q <= 1'b0;
    end else begin
      pair_q  <= {pair_q[0], raw_bit};
      odd_q   <= ~odd_q;
      valid_q <= last;
      if (take) begin
        shift_q <= next_shift;
        cnt_q   <= last ? '0 : cnt_q + 1'b1;
      end
      if (last)
        byte_q <= next_shift;
    end
  end

  assign byte_out   = byte_q;
  assign byte_valid = valid_q;

  AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) !enable |=> (!byte_valid && byte_out == '0 && cnt_q == '0)); // R1
  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!enable) !sample_en |=> (!odd_q && cnt_q == '0 && !byte_valid)); // R2
  AST_SKIP_EQUAL_PAIR: assert property (@(posedge clk) disable iff (!enable) (judge && pair_q[1] == pair_q[0]) |=> ($stable(cnt_q) && $stable(shift_q))); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!enable) byte_valid |=> !byte_valid); // R6
  AST_VALID_AT_WRAP: assert property (@(posedge clk) disable iff (!enable) byte_valid |-> (cnt_q == '0 && odd_q)); // R7
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!enable) (enable && !last) |=> $stable(byte_out)); // R6
endmodule

// File: tb/vn_byte_sampler_tb.sv
`timescale 1ns/1ps
module vn_byte_sampler_tb;
  logic clk = 1'b0;
  logic enable = 1'b0;
  logic sample_en = 1'b0;
  logic raw_bit = 1'b0;
  logic [7:0] byte_out;
  logic byte_valid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vn_byte_sampler #(.BYTE_W(8)) u_dut (
    .clk(clk), .enable(enable), .sample_en(sample_en), .raw_bit(raw_bit),
    .byte_out(byte_out), .byte_valid(byte_valid)
  );

  typedef struct packed {
    logic [31:0] stim;
    logic [7:0]  exp_byte;
    logic [7:0]  first_n;
    logic [1:0]  pulses;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{32'hAAAA_AAAA, 8'hFF, 8'd16, 2'd2},
    '{32'h5555_5555, 8'h00, 8'd16, 2'd2},
    '{32'h9999_9999, 8'hAA, 8'd16, 2'd2},
    '{32'h0FAA_AAAA, 8'hFF, 8'd24, 2'd1},
    '{32'h3C69_5A0F, 8'h63, 8'd24, 2'd1},
    '{32'h0000_00A6, 8'h00, 8'd0,  2'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_stream(input vec_t v, input string req);
    int seen = 0;
    @(negedge clk);
    sample_en = 1'b0;
    raw_bit = 1'b0;
    @(negedge clk);
    sample_en = 1'b1;
    raw_bit = v.stim[31];
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (byte_valid) begin
        check(j == int'(v.first_n) + 16 * seen, {req, " pulse edge"}, j, int'(v.first_n) + 16 * seen);
        check(byte_out == v.exp_byte, {req, " byte"}, byte_out, v.exp_byte);
        seen++;
      end
      raw_bit = (j + 1 < 32) ? v.stim[30 - j] : 1'b0;
    end
    check(seen == int'(v.pulses), {req, " pulse count"}, seen, v.pulses);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(byte_valid == 1'b0, "R1 reset valid", byte_valid, 0);
    check(byte_out == 8'h00, "R1 reset data", byte_out, 0);
    enable = 1'b1;

    foreach (TBL[i])
      run_stream(TBL[i], $sformatf("R3/R4/R5/R7 vec%0d", i));
    check(byte_out == 8'h63, "R2 R6 byte held after empty run", byte_out, 8'h63);

    // R1: partial byte is dropped by enable low
    @(negedge clk);
    sample_en = 1'b1;
    for (int b = 7; b >= 0; b--) begin
      raw_bit = b[0] ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    enable = 1'b0;
    @(negedge clk);
    check(byte_out == 8'h00 && !byte_valid, "R1 enable low clears", byte_out, 0);
    enable = 1'b1;
    run_stream(TBL[0], "R1 restart after enable");

    // R2: partial byte is dropped by sample_en low
    @(negedge clk);
    sample_en = 1'b1;
    for (int b = 0; b < 12; b++) begin
      raw_bit = b[0] ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    check(byte_out == 8'hFF, "R2 byte held during partial", byte_out, 8'hFF);
    run_stream(TBL[2], "R2 restart after sample_en");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule